// File: doc/BRIEF.md
# Configurable CRC Register Engine

This block computes a cyclic redundancy check under software control. Software sets four things through a small register-mapped slave port: the generator polynomial, the starting value, the checksum size (7, 8, 16 or 32 bits) and two bit-reversal switches. It then writes message data into a data register. Each data write is folded into a running remainder. The number of message bits consumed is set by the width of the access: a single byte lane folds 8 bits, a lane pair folds 16 and the full word folds 32. Long messages are sent as a sequence of writes of any mix of widths.

Reading the data register returns the current remainder, trimmed to the selected size and mirrored if output reversal is on. The polynomial register holds only the terms below the leading one, because the top term follows from the chosen size. A self-clearing control bit restarts the remainder from the programmed starting value.

Top module: `crc_regblock`

## Requirements
- R1: After reset the polynomial register reads 0x04C11DB7, the init register reads 0xFFFFFFFF, the control register reads 0 (32-bit size, no reversal) and the data register reads 0xFFFFFFFF.
- R2: Word index 0 on `bus_addr` selects the data register, 1 the polynomial, 2 the init value and 3 control. A write to polynomial or init changes only the bytes whose `bus_be` bit is set.
- R3: Control bits [1:0] select the size N: 00 gives 32, 01 gives 16, 10 gives 8 and 11 gives 7. The stored polynomial is used without its implied x^N term.
- R4: With input reversal off, data bits are folded most significant first. For each bit, the feedback is remainder bit N-1 XOR the data bit. The remainder shifts left by one within N bits, and the polynomial is XORed in when the feedback is 1.
- R5: A read of the data register returns zero in every bit at or above position N.
- R6: In a data write, `bus_be` = 1111 folds all 32 bits. 0011 folds bits [15:0] and 1100 folds bits [31:16]. A single set bit folds that byte lane. Any other pattern, including 0000, leaves the remainder unchanged.
- R7: The remainder carries from one data write to the next, and the updated value can be read in the cycle after the write.
- R8: Writing control with bit 4 set loads the remainder from the init register. Bit 4 always reads back as 0.
- R9: Control bit 2 mirrors each written unit (byte, half-word or word) within its own width before it is folded.
- R10: Control bit 3 mirrors the N-bit remainder on data-register reads.
- R11: With init 0, N = 8, polynomial 0x97 and one word write of 0xA5A5A5A5, the data register reads 0x5A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register word index |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr`, combinational |

## Verification
A fault in the remainder register or the fold network shows up on the next read of the data register, one cycle after the write that caused it. Every message later folded into that remainder carries the same error, so it cannot hide behind further data. A wrong lane or width decode gives a checksum that differs from a bit-serial model, even when byte lanes are rotated across a known message. A stuck reversal or size field gives results that differ from catalogued check values for "123456789". A lost reload shows up when the very next read does not equal the init value.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned CRC_MAX = 32;

  typedef enum logic [1:0] {SZ_32 = 2'd0, SZ_16 = 2'd1, SZ_8 = 2'd2, SZ_7 = 2'd3} crc_size_e;

  typedef struct packed {
    logic      mirror_out;
    logic      mirror_in;
    crc_size_e size;
  } crc_cfg_t;

  function automatic logic [5:0] size_bits(input crc_size_e s);
    case (s)
      SZ_16:   return 6'd16;
      SZ_8:    return 6'd8;
      SZ_7:    return 6'd7;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [CRC_MAX-1:0] width_mask(input logic [5:0] n);
    if (n >= 6'd32) return '1;
    return (32'd1 << n) - 32'd1;
  endfunction

  // mirror the low n bits of v, upper bits become zero
  function automatic logic [CRC_MAX-1:0] reverse_n(input logic [CRC_MAX-1:0] v, input logic [5:0] n);
    logic [CRC_MAX-1:0] r;
    r = '0;
    for (int i = 0; i < CRC_MAX; i++)
      if (i < int'(n)) r[int'(n) - 1 - i] = v[i];
    return r;
  endfunction

  // fold cnt bits of din (left aligned, MSB first) into remainder of width n
  function automatic logic [CRC_MAX-1:0] fold_bits(input logic [CRC_MAX-1:0] rem,
                                                   input logic [CRC_MAX-1:0] din,
                                                   input logic [5:0] cnt,
                                                   input logic [CRC_MAX-1:0] poly,
                                                   input logic [5:0] n);
    logic [CRC_MAX-1:0] r, m, p;
    logic fb;
    m = width_mask(n);
    r = rem & m;
    p = poly & m;
    for (int i = 0; i < CRC_MAX; i++) begin
      if (i < int'(cnt)) begin
        fb = r[n - 6'd1] ^ din[CRC_MAX - 1 - i];
        r  = (r << 1) & m;
        if (fb) r = r ^ p;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/crc_unit_pick.sv
module crc_unit_pick
  import crc_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  localparam int unsigned LANES = BUS_W / 8
) (
  input  logic [LANES-1:0] be,
  input  logic [BUS_W-1:0] wdata,
  input  logic             mirror_in,
  output logic             unit_ok,
  output logic [5:0]       unit_bits,
  output logic [BUS_W-1:0] unit_left
);
  logic [7:0] lane [LANES];
  logic is_byte, is_half, is_word;
  logic [BUS_W-1:0] raw_left, raw_right;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane[k] = wdata[8*k +: 8];
  end

  always_comb begin
    is_byte  = 1'b0;
    is_half  = 1'b0;
    is_word  = 1'b0;
    raw_left = '0;
    case (be)
      4'b1111: begin is_word = 1'b1; raw_left = wdata; end
      4'b0011: begin is_half = 1'b1; raw_left = {lane[1], lane[0], 16'h0}; end
      4'b1100: begin is_half = 1'b1; raw_left = {lane[3], lane[2], 16'h0}; end
      4'b0001: begin is_byte = 1'b1; raw_left = {lane[0], 24'h0}; end
      4'b0010: begin is_byte = 1'b1; raw_left = {lane[1], 24'h0}; end
      4'b0100: begin is_byte = 1'b1; raw_left = {lane[2], 24'h0}; end
      4'b1000: begin is_byte = 1'b1; raw_left = {lane[3], 24'h0}; end
      default: raw_left = '0;
    endcase
  end

  assign unit_ok   = is_byte | is_half | is_word;
  assign unit_bits = is_word ? 6'd32 : (is_half ? 6'd16 : (is_byte ? 6'd8 : 6'd0));
  assign raw_right = raw_left >> (6'd32 - unit_bits);
  assign unit_left = mirror_in ? (reverse_n(raw_right, unit_bits) << (6'd32 - unit_bits)) : raw_left;

  always_comb begin
    a_r6_one_width: assert ($onehot0({is_byte, is_half, is_word}));
  end
endmodule

// File: rtl/crc_fold.sv
module crc_fold
  import crc_pkg::*;
(
  input  logic [CRC_MAX-1:0] rem_in,
  input  logic [CRC_MAX-1:0] din_left,
  input  logic [5:0]         din_bits,
  input  logic [CRC_MAX-1:0] poly,
  input  logic [5:0]         crc_n,
  output logic [CRC_MAX-1:0] rem_out
);
  assign rem_out = fold_bits(rem_in, din_left, din_bits, poly, crc_n);
endmodule

// File: rtl/crc_regblock.sv
module crc_regblock
  import crc_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter logic [31:0] POLY_RST = 32'h04C1_1DB7,
  parameter logic [31:0] INIT_RST = 32'hFFFF_FFFF,
  localparam int unsigned LANES = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [LANES-1:0] bus_be,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata
);
  localparam logic [1:0] A_DATA = 2'd0, A_POLY = 2'd1, A_INIT = 2'd2, A_CTRL = 2'd3;

  logic [BUS_W-1:0] poly_q, init_q, rem_q, fold_out, unit_left, rem_view;
  crc_cfg_t         cfg_q;
  logic [5:0]       crc_n, unit_bits;
  logic             unit_ok, wr_data, ev_fold, ev_reload;

  function automatic logic [BUS_W-1:0] be_merge(input logic [BUS_W-1:0] old_v,
                                                input logic [BUS_W-1:0] new_v,
                                                input logic [LANES-1:0] be);
    logic [BUS_W-1:0] r;
    r = old_v;
    for (int k = 0; k < LANES; k++)
      if (be[k]) r[8*k +: 8] = new_v[8*k +: 8];
    return r;
  endfunction

  assign crc_n     = size_bits(cfg_q.size);
  assign wr_data   = bus_sel & bus_wr & (bus_addr == A_DATA);
  assign ev_fold   = wr_data & unit_ok;
  assign ev_reload = bus_sel & bus_wr & (bus_addr == A_CTRL) & bus_be[0] & bus_wdata[4];

  crc_unit_pick #(.BUS_W(BUS_W)) u_pick (
    .be        (bus_be),
    .wdata     (bus_wdata),
    .mirror_in (cfg_q.mirror_in),
    .unit_ok   (unit_ok),
    .unit_bits (unit_bits),
    .unit_left (unit_left)
  );

  crc_fold u_fold (
    .rem_in   (rem_q),
    .din_left (unit_left),
    .din_bits (unit_bits),
    .poly     (poly_q),
    .crc_n    (crc_n),
    .rem_out  (fold_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poly_q <= POLY_RST;
      init_q <= INIT_RST;
      cfg_q  <= '0;
    end else if (bus_sel && bus_wr) begin
      if (bus_addr == A_POLY) poly_q <= be_merge(poly_q, bus_wdata, bus_be);
      if (bus_addr == A_INIT) init_q <= be_merge(init_q, bus_wdata, bus_be);
      if (bus_addr == A_CTRL && bus_be[0]) cfg_q <= crc_cfg_t'(bus_wdata[3:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rem_q <= INIT_RST;
    else if (ev_reload) rem_q <= init_q;
    else if (ev_fold)   rem_q <= fold_out;
  end

  assign rem_view = cfg_q.mirror_out ? reverse_n(rem_q & width_mask(crc_n), crc_n)
                                     : (rem_q & width_mask(crc_n));

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = rem_view;
      A_POLY:  bus_rdata = poly_q;
      A_INIT:  bus_rdata = init_q;
      default: bus_rdata = {28'h0, cfg_q};
    endcase
  end

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_DATA) |-> ((bus_rdata & ~width_mask(crc_n)) == '0));

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_fold && !ev_reload) |=> $stable(rem_q));

  a_r6_bad_be_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !unit_ok) |=> $stable(rem_q));

  a_r8_reload_loads_init: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reload |=> (rem_q == $past(init_q)));
endmodule

// File: tb/sim_crc_regblock.sv
module sim_crc_regblock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [3:0]  bus_be = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  crc_regblock u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
                   .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
                   .bus_rdata(bus_rdata));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // bench model: value right aligned, nb bits, lsb-first when mirrored
  function automatic logic [31:0] model(input logic [31:0] r, input logic [31:0] v, input int nb,
                                        input logic [31:0] p, input int n, input bit mir);
    logic [31:0] m;
    m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
    for (int k = 0; k < nb; k++) begin
      logic b, top;
      b   = mir ? v[k] : v[nb - 1 - k];
      top = (r >> (n - 1)) & 1'b1;
      r   = r << 1;
      if (top ^ b) r = r ^ p;
      r = r & m;
    end
    return r;
  endfunction

  function automatic logic [7:0] msg(input int i);
    return 8'h31 + 8'(i);
  endfunction

  task automatic setup(input logic [1:0] sz, input logic [31:0] p, input logic [31:0] ini, input logic [3:0] flags);
    wr(2'd1, 4'hF, p);
    wr(2'd2, 4'hF, ini);
    wr(2'd3, 4'h1, 32'h10 | {28'h0, flags} | {30'h0, sz});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd1, d); chk("R1 poly reset", d, 32'h04C11DB7);
    rd(2'd2, d); chk("R1 init reset", d, 32'hFFFFFFFF);
    rd(2'd3, d); chk("R1 ctrl reset", d, 32'h0);
    rd(2'd0, d); chk("R1 data reset", d, 32'hFFFFFFFF);
  endtask

  task automatic t_cfg_bytes;
    logic [31:0] d;
    wr(2'd1, 4'b0001, 32'hAABBCCFF);
    rd(2'd1, d); chk("R2 poly byte enable", d, 32'h04C11DFF);
    wr(2'd2, 4'b1000, 32'h12000000);
    rd(2'd2, d); chk("R2 init byte enable", d, 32'h12FFFFFF);
  endtask

  task automatic t_vector;
    logic [31:0] d;
    setup(2'b10, 32'h97, 32'h0, 4'h0);
    wr(2'd0, 4'hF, 32'hA5A5A5A5);
    rd(2'd0, d); chk("R11 self-check vector", d, 32'h5A);
    chk("R4 model agrees", d, model(32'h0, 32'hA5A5A5A5, 32, 32'h97, 8, 1'b0));
  endtask

  task automatic t_crc8_lanes;
    logic [31:0] d, e;
    setup(2'b10, 32'h07, 32'h0, 4'h0);
    e = 0;
    for (int i = 0; i < 9; i++) begin
      int ln;
      ln = i % 4;
      wr(2'd0, 4'(1 << ln), {24'h0, msg(i)} << (8 * ln));
      e = model(e, {24'h0, msg(i)}, 8, 32'h07, 8, 1'b0);
    end
    rd(2'd0, d);
    chk("R6 byte lanes crc8", d, 32'hF4);
    chk("R4 byte lanes model", d, e);
    chk("R5 upper bits zero", d & 32'hFFFFFF00, 32'h0);
  endtask

  task automatic t_bad_be;
    logic [31:0] d;
    wr(2'd0, 4'b0101, 32'h12345678);
    rd(2'd0, d); chk("R6 be 0101 ignored", d, 32'hF4);
    wr(2'd0, 4'b0000, 32'h12345678);
    rd(2'd0, d); chk("R6 be 0000 ignored", d, 32'hF4);
    wr(2'd0, 4'b0111, 32'h12345678);
    rd(2'd0, d); chk("R6 be 0111 ignored", d, 32'hF4);
  endtask

  task automatic t_revout8;
    logic [31:0] d;
    wr(2'd3, 4'h1, 32'h0000000A);
    rd(2'd0, d); chk("R10 output mirror 8 bit", d, 32'h2F);
    rd(2'd3, d); chk("R8 reload bit reads zero", d, 32'hA);
  endtask

  task automatic t_crc16_mixed;
    logic [31:0] d, e;
    setup(2'b01, 32'h1021, 32'hFFFF, 4'h0);
    wr(2'd0, 4'b0011, 32'h00003132);
    e = model(32'hFFFF, 32'h3132, 16, 32'h1021, 16, 1'b0);
    rd(2'd0, d); chk("R7 readable after first write", d, e);
    wr(2'd0, 4'b1100, 32'h33340000);
    wr(2'd0, 4'b0011, 32'h00003536);
    wr(2'd0, 4'b1100, 32'h37380000);
    wr(2'd0, 4'b0100, 32'h00390000);
    rd(2'd0, d); chk("R7 mixed widths crc16", d, 32'h29B1);
  endtask

  task automatic t_crc7;
    logic [31:0] d;
    setup(2'b11, 32'h09, 32'h0, 4'h0);
    for (int i = 0; i < 9; i++) wr(2'd0, 4'b0001, {24'h0, msg(i)});
    rd(2'd0, d); chk("R3 seven bit size", d, 32'h75);
  endtask

  task automatic t_crc32;
    logic [31:0] d;
    setup(2'b00, 32'h04C11DB7, 32'hFFFFFFFF, 4'h0);
    wr(2'd0, 4'hF, 32'h31323334);
    wr(2'd0, 4'hF, 32'h35363738);
    wr(2'd0, 4'b1000, 32'h39000000);
    rd(2'd0, d); chk("R3 32 bit size", d, 32'h0376E6E7);
  endtask

  task automatic t_reflect;
    logic [31:0] d;
    setup(2'b00, 32'h04C11DB7, 32'hFFFFFFFF, 4'hC);
    for (int i = 0; i < 9; i++) wr(2'd0, 4'b0010, {16'h0, msg(i), 8'h0});
    rd(2'd0, d); chk("R9 mirrored input crc32", d, 32'h340BC6D9);
  endtask

  task automatic t_reload;
    logic [31:0] d;
    setup(2'b01, 32'h1021, 32'h0001ABCD, 4'h0);
    wr(2'd0, 4'hF, 32'hDEADBEEF);
    wr(2'd3, 4'h1, 32'h11);
    rd(2'd0, d); chk("R8 reload from init", d, 32'hABCD);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_cfg_bytes;
    t_vector;
    t_crc8_lanes;
    t_bad_be;
    t_revout8;
    t_crc16_mixed;
    t_crc7;
    t_crc32;
    t_reflect;
    t_reload;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule